// File: doc/BRIEF.md
# Chopped-Light Background Canceller

This block switches an infrared emitter on and off with a square wave and processes digitized photodetector samples so that ambient light drops out of the result. With the default parameters and a 50 MHz clock, each half of the chop cycle lasts about 25,000 clocks, which gives a nominal chop rate of 1 kHz.

The half-period is not fixed. It is swept up and down by a slow triangular profile, ±6 % by default, with a 50 Hz repeat. Because of this sweep, a periodic background whose frequency is an integer multiple of the chop rate does not lock to it. Such a background still averages out.

Each detector sample updates a first-order low-pass estimate. A sample taken while the emitter is lit enters the estimate as it is. A sample taken while the emitter is dark enters it negated. Ambient light is present in both halves, so it cancels. Reflected light is present only in the lit half, so it remains in the estimate. The first sample after every emitter edge is dropped to allow the optics and converter to settle.

Top module: `chop_canceller`

## Requirements
- R1: While `rst` is high, at the following clock edge `emit_on`, `est` and `est_vld` are all 0, and the sweep offset returns to zero with its direction set to rising.
- R2: After reset the emitter is dark (`emit_on`=0) for exactly HALF_BASE clocks. From then on, `emit_on` toggles once at the end of every half-period, and no half-period is shorter than two clocks.
- R3: The length of each half-period is HALF_BASE plus a signed sweep offset.
  - The offset starts at 0 and changes by STEP at every emitter edge, where SPAN = HALF_BASE·SPAN_PCT/100 and STEP = 2·SPAN/RAMP_HALVES.
  - It first rises. It reverses direction whenever the next step would move it beyond ±SPAN.
- R4: The sweep offset never leaves the range −SPAN to +SPAN.
- R5: After reset, and after every emitter edge, the first sample with `samp_vld` high is discarded. It produces no `est_vld` and leaves `est` unchanged.
- R6: An accepted sample takes its sign from the value of `emit_on` in the same cycle: positive when `emit_on`=1, negated when `emit_on`=0. The sample arriving in the same cycle as an edge still uses the old phase.
- R7: For an accepted signed sample x, the estimate becomes y + ((±x − y) >>> AVG_SHIFT), computed in two's complement with an arithmetic right shift. The new value appears on `est` one clock after the sample, together with a single-cycle `est_vld`. The negation of the most negative sample is represented exactly.
- R8: In any cycle without an accepted sample, `est` holds its value and `est_vld` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| samp_vld | input | 1 | A new detector sample is present this cycle |
| samp | input | SAMP_W | Signed detector sample |
| emit_on | output | 1 | Emitter enable, 1 = lit |
| est | output | SAMP_W+1 | Signed averaged difference estimate |
| est_vld | output | 1 | One-cycle pulse when `est` has just been updated |

## Verification
The embedded properties check the following on every cycle:
- the sweep offset stays within its bounds;
- the offset moves by exactly one step at each edge;
- the half-period counter stays below its current limit;
- the emitter never toggles on two adjacent cycles;
- the estimate holds whenever no update is flagged;
- the sample just after an edge is never accepted;
- the reset state is correct.

Only the bench scenarios can show the rest:
- the exact sequence of half-period lengths along the triangle, including the reversal points;
- the signed value of every estimate under several ambient and signal patterns, including a full-scale negative sample;
- a restart from a reset applied mid-run.

// File: rtl/chop_pkg.sv
package chop_pkg;

    // Emitter phase; the encoding is also the sign selector (1 = add)
    typedef enum logic {
        PH_DARK = 1'b0,
        PH_LIT  = 1'b1
    } phase_e;

    typedef enum logic {
        SW_UP   = 1'b0,
        SW_DOWN = 1'b1
    } sweep_dir_e;

    // Sweep excursion in clocks for a given base half-period and percentage
    function automatic int span_of(input int base, input int pct);
        return (base * pct) / 100;
    endfunction

    // Offset change per half-period so that one ramp spans 2*span
    function automatic int step_of(input int span, input int halves);
        int s;
        s = (halves > 0) ? (2 * span) / halves : 0;
        return s;
    endfunction

endpackage

// File: rtl/chop_sweep.sv
module chop_sweep
    import chop_pkg::*;
#(
    parameter int HALF_BASE = 25000,
    parameter int SPAN      = 1500,
    parameter int STEP      = 150,
    parameter int CW        = 15
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          adv,
    output logic [CW-1:0] half_len
);

    localparam logic signed [CW:0] SPAN_S = (CW+1)'(SPAN);
    localparam logic signed [CW:0] STEP_S = (CW+1)'(STEP);
    localparam logic signed [CW:0] BASE_S = (CW+1)'(HALF_BASE);

    logic signed [CW:0] ofs_q;
    logic signed [CW:0] len_s;
    sweep_dir_e         dir_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ofs_q <= '0;
            dir_q <= SW_UP;
        end else if (adv) begin
            if (dir_q == SW_UP) begin
                if (ofs_q + STEP_S > SPAN_S) begin
                    dir_q <= SW_DOWN;
                    ofs_q <= ofs_q - STEP_S;
                end else begin
                    ofs_q <= ofs_q + STEP_S;
                end
            end else begin
                if (ofs_q - STEP_S < -SPAN_S) begin
                    dir_q <= SW_UP;
                    ofs_q <= ofs_q + STEP_S;
                end else begin
                    ofs_q <= ofs_q - STEP_S;
                end
            end
        end
    end

    assign len_s    = BASE_S + ofs_q;
    assign half_len = len_s[CW-1:0];

    // R4
    offset_range_chk: assert property (@(posedge clk) disable iff (rst)
        (ofs_q <= SPAN_S) && (ofs_q >= -SPAN_S));

    // R3
    offset_step_chk: assert property (@(posedge clk) disable iff (rst)
        adv |=> ((ofs_q == $past(ofs_q) + STEP_S) || (ofs_q == $past(ofs_q) - STEP_S)));

endmodule

// File: rtl/chop_phase.sv
module chop_phase
    import chop_pkg::*;
#(
    parameter int CW = 15
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] half_len,
    output phase_e        phase,
    output logic          edge_o
);

    logic [CW-1:0] cnt_q;
    phase_e        ph_q;
    logic          last;

    assign last = ((cnt_q + 1'b1) >= half_len);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            ph_q  <= PH_DARK;
        end else if (last) begin
            cnt_q <= '0;
            ph_q  <= (ph_q == PH_LIT) ? PH_DARK : PH_LIT;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign phase  = ph_q;
    assign edge_o = last;

    // R2
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q < half_len);

    // R2
    toggle_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (ph_q != $past(ph_q)) |=> (ph_q == $past(ph_q)));

endmodule

// File: rtl/chop_avg.sv
module chop_avg
    import chop_pkg::*;
#(
    parameter int W     = 12,
    parameter int SHIFT = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                edge_i,
    input  phase_e              phase,
    input  logic                vld,
    input  logic signed [W-1:0] samp,
    output logic signed [W:0]   est,
    output logic                est_vld
);

    localparam int XW = W + 1;
    localparam int DW = W + 2;

    logic                 skip_q;
    logic                 take;
    logic signed [XW-1:0] sx;
    logic signed [DW-1:0] diff;
    logic signed [DW-1:0] stepv;
    logic signed [DW-1:0] ysum;
    logic signed [XW-1:0] y_q;
    logic                 est_vld_q;

    assign take = vld && !skip_q;

    always_comb begin
        sx    = (phase == PH_LIT) ? XW'(samp) : -XW'(samp);
        diff  = DW'(sx) - DW'(y_q);
        stepv = diff >>> SHIFT;
        ysum  = DW'(y_q) + stepv;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            skip_q    <= 1'b1;
            y_q       <= '0;
            est_vld_q <= 1'b0;
        end else begin
            if (edge_i) skip_q <= 1'b1;
            else if (vld) skip_q <= 1'b0;
            if (take) y_q <= ysum[XW-1:0];
            est_vld_q <= take;
        end
    end

    assign est     = y_q;
    assign est_vld = est_vld_q;

    // R8
    est_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !est_vld_q |-> (y_q == $past(y_q)));

    // R5
    settle_skip_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(edge_i) && vld) |=> !est_vld_q);

endmodule

// File: rtl/chop_canceller.sv
module chop_canceller
    import chop_pkg::*;
#(
    parameter int SAMP_W      = 12,
    parameter int AVG_SHIFT   = 4,
    parameter int HALF_BASE   = 25000,
    parameter int SPAN_PCT    = 6,
    parameter int RAMP_HALVES = 20
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     samp_vld,
    input  logic signed [SAMP_W-1:0] samp,
    output logic                     emit_on,
    output logic signed [SAMP_W:0]   est,
    output logic                     est_vld
);

    localparam int SPAN = span_of(HALF_BASE, SPAN_PCT);
    localparam int STEP = step_of(SPAN, RAMP_HALVES);
    localparam int CW   = $clog2(HALF_BASE + SPAN + 1);

    logic [CW-1:0] half_len;
    phase_e        phase;
    logic          chop_edge;

    chop_sweep #(
        .HALF_BASE (HALF_BASE),
        .SPAN      (SPAN),
        .STEP      (STEP),
        .CW        (CW)
    ) i_sweep (
        .clk      (clk),
        .rst      (rst),
        .adv      (chop_edge),
        .half_len (half_len)
    );

    chop_phase #(
        .CW (CW)
    ) i_phase (
        .clk      (clk),
        .rst      (rst),
        .half_len (half_len),
        .phase    (phase),
        .edge_o   (chop_edge)
    );

    chop_avg #(
        .W     (SAMP_W),
        .SHIFT (AVG_SHIFT)
    ) i_avg (
        .clk     (clk),
        .rst     (rst),
        .edge_i  (chop_edge),
        .phase   (phase),
        .vld     (samp_vld),
        .samp    (samp),
        .est     (est),
        .est_vld (est_vld)
    );

    assign emit_on = (phase == PH_LIT);

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (!emit_on && (est == '0) && !est_vld));

endmodule

// File: tb/test_chop_canceller.sv
module test_chop_canceller;

    localparam int W      = 12;
    localparam int SH     = 4;
    localparam int N_HALF = 10;
    localparam int N_SCN  = 5;

    // Half-period lengths for base 20, span 4, step 2
    localparam int HALF_EXP [N_HALF] = '{20, 22, 24, 22, 20, 18, 16, 18, 20, 22};

    // Scenario vectors: ambient, reflected signal, sample gap, cycles
    localparam int SCN [N_SCN][4] = '{
        '{  500,  300, 2, 400},
        '{ 1500,  500, 3, 300},
        '{-2048,    0, 1, 200},
        '{    0, 2047, 1, 200},
        '{ -300, -200, 5, 300}
    };

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic                samp_vld = 1'b0;
    logic signed [W-1:0] samp = '0;
    logic                emit_on;
    logic signed [W:0]   est;
    logic                est_vld;

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;

    int  exp_y;
    bit  pend;
    bit  skip_m;
    bit  last_emit;
    int  half_cnt;
    int  half_idx;
    int  tick;

    always #10 clk = ~clk;

    chop_canceller #(
        .SAMP_W      (W),
        .AVG_SHIFT   (SH),
        .HALF_BASE   (20),
        .SPAN_PCT    (20),
        .RAMP_HALVES (4)
    ) i_chop_canceller (
        .clk      (clk),
        .rst      (rst),
        .samp_vld (samp_vld),
        .samp     (samp),
        .emit_on  (emit_on),
        .est      (est),
        .est_vld  (est_vld)
    );

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, expv, $time);
        end
    endtask

    task automatic model_init();
        exp_y     = 0;
        pend      = 1'b0;
        skip_m    = 1'b1;
        last_emit = 1'b0;
        half_cnt  = 0;
        half_idx  = 0;
        tick      = 0;
    endtask

    // Reset and check the R1 state at the ports
    task automatic do_reset();
        @(negedge clk);
        rst      = 1'b1;
        samp_vld = 1'b0;
        repeat (3) @(negedge clk);
        check(emit_on == 1'b0, "R1 emit_on", int'(emit_on), 0);
        check(est == '0,       "R1 est",     int'($signed(est)), 0);
        check(est_vld == 1'b0, "R1 est_vld", int'(est_vld), 0);
        rst = 1'b0;
        model_init();
    endtask

    // One negedge: check previous result, track phase, drive next sample
    task automatic step(input int amb, input int sig, input int gap);
        int v;
        int sx;
        bit drive;
        @(negedge clk);
        check(est_vld == pend, "R7 R8 est_vld", int'(est_vld), int'(pend));
        check($signed(est) == exp_y, "R6 R7 R8 est", int'($signed(est)), exp_y);
        half_cnt++;
        if (emit_on != last_emit) begin
            if (half_idx < N_HALF)
                check(half_cnt == HALF_EXP[half_idx],
                      (half_idx == 0) ? "R2 first half" : "R3 half length",
                      half_cnt, HALF_EXP[half_idx]);
            half_idx++;
            half_cnt  = 0;
            skip_m    = 1'b1;
            last_emit = emit_on;
        end
        drive = ((tick % gap) == 0);
        tick++;
        v  = amb + (emit_on ? sig : 0);
        pend = 1'b0;
        if (drive) begin
            if (skip_m) begin
                skip_m = 1'b0;           // R5 settle sample dropped
            end else begin
                sx    = emit_on ? v : -v;
                exp_y = exp_y + ((sx - exp_y) >>> SH);
                pend  = 1'b1;
            end
        end
        samp_vld = drive;
        samp     = W'(v);
    endtask

    initial begin
        #4_000_000;
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R2 R3 half lengths checked during the first scenario
        for (int s = 0; s < N_SCN; s++) begin
            for (int c = 0; c < SCN[s][3]; c++)
                step(SCN[s][0], SCN[s][1], SCN[s][2]);
        end
        check(half_idx >= N_HALF, "R3 halves seen", half_idx, N_HALF);

        // Directed: reset mid-run, then the sweep restarts from zero offset
        do_reset();
        for (int c = 0; c < 250; c++) step(-1000, 400, 2);
        check(half_idx >= N_HALF, "R1 R2 restart halves", half_idx, N_HALF);

        // Directed: idle input, estimate must hold (R8)
        for (int c = 0; c < 60; c++) step(0, 0, 1000);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule